// File: doc/BRIEF.md
# Dual Host Transaction Request Queues

This block stores pending host transaction requests in two independent first-in first-out queues. One queue carries periodic traffic and the other carries non-periodic traffic. Each queue takes a request from the application side and hands it to the scheduler side. A request names a token type, a host channel and a terminate flag.

For each queue the block outputs a read-only status word. The word holds the number of free entries in the queue and the decoded fields of the entry at the head of the queue. It also carries the free space of the matching transmit data FIFO, which enters as an input and is passed through unchanged. Software reads the free count before it posts a request.

A push into a full queue is dropped and sets a sticky overflow flag. A pop from an empty queue does nothing.

Top module: `host_req_queues`

## Requirements
- R1: After reset, each queue reports a free count equal to DEPTH, head fields of zero, and an overflow flag of 0.
- R2: An accepted push lowers the queue's free count by one, and an accepted pop raises it by one. The change is visible in the cycle after the clock edge that samples the request.
- R3: Entries leave a queue in the order in which they were pushed. The head fields always describe the oldest stored entry.
- R4: Status word layout, with the default parameters: bits [15:0] carry the data-space input, bits [19:16] the free count, bits [21:20] the head token type (00 IN/OUT, 01 zero-length, 10 ping/complete-split, 11 channel halt), bits [25:22] the head channel number, and bit 26 the head terminate flag.
- R5: A push into a full queue is dropped. The stored contents and the free count of 0 stay unchanged, and the queue's overflow flag is set to 1. The flag then stays at 1 until reset.
- R6: A pop from an empty queue has no effect. The free count stays at DEPTH and the head fields stay at zero.
- R7: When a push and a pop arrive in the same cycle on a queue that is neither empty nor full, the free count does not change and the head moves to the next entry.
- R8: While a queue is empty, its head token, channel and terminate fields read as zero.
- R9: The two queues are independent. Activity on one queue changes neither the status nor the overflow flag of the other.
- R10: The data-space field of each status word follows its input in the same cycle, without a register in the path.
- R11: When a push and a pop arrive in the same cycle on an empty queue, the push is stored and the pop is ignored. The free count becomes DEPTH-1 and the head shows the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| per_push | input | 1 | Push a request into the periodic queue |
| per_tok | input | 2 | Token type of the periodic request |
| per_ch | input | CH_W | Channel number of the periodic request |
| per_term | input | 1 | Terminate flag of the periodic request |
| per_pop | input | 1 | Pop the head of the periodic queue |
| per_space | input | SPACE_W | Free space of the periodic data FIFO, passed through |
| per_status | output | STAT_W | Status word of the periodic queue |
| per_overflow | output | 1 | Sticky flag for a push into the full periodic queue |
| np_push | input | 1 | Push a request into the non-periodic queue |
| np_tok | input | 2 | Token type of the non-periodic request |
| np_ch | input | CH_W | Channel number of the non-periodic request |
| np_term | input | 1 | Terminate flag of the non-periodic request |
| np_pop | input | 1 | Pop the head of the non-periodic queue |
| np_space | input | SPACE_W | Free space of the non-periodic data FIFO, passed through |
| np_status | output | STAT_W | Status word of the non-periodic queue |
| np_overflow | output | 1 | Sticky flag for a push into the full non-periodic queue |

## Verification
The bench builds the block with the default parameters: DEPTH of 8, CH_W of 4 and SPACE_W of 16. With these values the status fields sit at the bit positions stated in R4. The depth of 8 lets a short directed sequence fill a queue completely, push once more into it, and then drain it. That sequence exercises pointer wrap, the overflow flag and FIFO order together. Four-bit channels allow the value 15, so the widest channel field is checked as well.

// File: rtl/host_req_queues.sv
module host_req_queues #(
  parameter int DEPTH   = 8,
  parameter int CH_W    = 4,
  parameter int SPACE_W = 16,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int ENT_W  = CH_W + 3,
  localparam int STAT_W = ENT_W + CNT_W + SPACE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               per_push,
  input  logic [1:0]         per_tok,
  input  logic [CH_W-1:0]    per_ch,
  input  logic               per_term,
  input  logic               per_pop,
  input  logic [SPACE_W-1:0] per_space,
  output logic [STAT_W-1:0]  per_status,
  output logic               per_overflow,
  input  logic               np_push,
  input  logic [1:0]         np_tok,
  input  logic [CH_W-1:0]    np_ch,
  input  logic               np_term,
  input  logic               np_pop,
  input  logic [SPACE_W-1:0] np_space,
  output logic [STAT_W-1:0]  np_status,
  output logic               np_overflow
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]         push_v, pop_v, ovf_v;
  logic [ENT_W-1:0]   ent_v   [2];
  logic [SPACE_W-1:0] space_v [2];
  logic [STAT_W-1:0]  stat_v  [2];

  assign push_v     = {np_push, per_push};
  assign pop_v      = {np_pop, per_pop};
  assign ent_v[0]   = {per_term, per_ch, per_tok};
  assign ent_v[1]   = {np_term, np_ch, np_tok};
  assign space_v[0] = per_space;
  assign space_v[1] = np_space;

  assign per_status   = stat_v[0];
  assign np_status    = stat_v[1];
  assign per_overflow = ovf_v[0];
  assign np_overflow  = ovf_v[1];

  for (genvar q = 0; q < 2; q++) begin : g_q
    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd, wr;
    logic [CNT_W-1:0] cnt;
    logic             ovf;
    logic [ENT_W-1:0] head;
    logic [CNT_W-1:0] free;
    logic             full, empty, do_push, do_pop;

    assign full    = (cnt == CNT_W'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push_v[q] && !full;
    assign do_pop  = pop_v[q] && !empty;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd  <= '0;
        wr  <= '0;
        cnt <= '0;
        ovf <= 1'b0;
      end else begin
        if (do_push) wr <= (wr == PTR_W'(DEPTH - 1)) ? '0 : wr + 1'b1;
        if (do_pop)  rd <= (rd == PTR_W'(DEPTH - 1)) ? '0 : rd + 1'b1;
        if (do_push && !do_pop)      cnt <= cnt + 1'b1;
        else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        if (push_v[q] && full) ovf <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (do_push) mem[wr] <= ent_v[q];
    end

    assign head      = empty ? '0 : mem[rd];
    assign free      = CNT_W'(DEPTH) - cnt;
    assign stat_v[q] = {head, free, space_v[q]};
    assign ovf_v[q]  = ovf;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(DEPTH)); // R2
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push_v[q] && !pop_v[q]) |=> (free == '0 && ovf)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf); // R5
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop_v[q] && !push_v[q]) |=> (free == CNT_W'(DEPTH))); // R6
    AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !full && push_v[q] && pop_v[q]) |=> $stable(free)); // R7
    AST_EMPTY_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
      (free == CNT_W'(DEPTH)) |-> (stat_v[q][STAT_W-1 -: ENT_W] == '0)); // R8
  end
endmodule

// File: tb/tb_host_req_queues.sv
module tb_host_req_queues;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic per_push = 0, per_term = 0, per_pop = 0;
  logic np_push = 0, np_term = 0, np_pop = 0;
  logic [1:0] per_tok = 0, np_tok = 0;
  logic [3:0] per_ch = 0, np_ch = 0;
  logic [15:0] per_space = 0, np_space = 0;
  logic [26:0] per_status, np_status;
  logic per_overflow, np_overflow;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_req_queues dut (.*);

  // {push,pop,tok,ch,term, exp_free,exp_tok,exp_ch,exp_term}
  localparam logic [19:0] VEC [10] = '{
    {1'b1,1'b0,2'd1,4'd3,1'b0,  4'd7,2'd1,4'd3,1'b0},
    {1'b1,1'b0,2'd2,4'd5,1'b1,  4'd6,2'd1,4'd3,1'b0},
    {1'b1,1'b0,2'd3,4'd15,1'b1, 4'd5,2'd1,4'd3,1'b0},
    {1'b1,1'b1,2'd0,4'd9,1'b0,  4'd5,2'd2,4'd5,1'b1},
    {1'b0,1'b1,2'd0,4'd0,1'b0,  4'd6,2'd3,4'd15,1'b1},
    {1'b0,1'b1,2'd0,4'd0,1'b0,  4'd7,2'd0,4'd9,1'b0},
    {1'b0,1'b1,2'd0,4'd0,1'b0,  4'd8,2'd0,4'd0,1'b0},
    {1'b0,1'b1,2'd0,4'd0,1'b0,  4'd8,2'd0,4'd0,1'b0},
    {1'b1,1'b1,2'd1,4'd1,1'b1,  4'd7,2'd1,4'd1,1'b1},
    {1'b0,1'b1,2'd0,4'd0,1'b0,  4'd8,2'd0,4'd0,1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic per_step(logic pu, logic po, logic [1:0] t, logic [3:0] c, logic tm);
    @(negedge clk);
    per_push = pu; per_pop = po; per_tok = t; per_ch = c; per_term = tm;
    @(posedge clk); #1;
    per_push = 0; per_pop = 0;
  endtask

  task automatic np_step(logic pu, logic po, logic [1:0] t, logic [3:0] c, logic tm);
    @(negedge clk);
    np_push = pu; np_pop = po; np_tok = t; np_ch = c; np_term = tm;
    @(posedge clk); #1;
    np_push = 0; np_pop = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 per free", per_status[19:16], 8);
    check("R1 per head", per_status[26:20], 0);
    check("R1 np free", np_status[19:16], 8);
    check("R1 overflow", {per_overflow, np_overflow}, 0);

    for (int i = 0; i < 10; i++) begin
      logic [19:0] v;
      v = VEC[i];
      per_step(v[19], v[18], v[17:16], v[15:12], v[11]);
      check($sformatf("R2/R3/R7/R6/R11 vec%0d free", i), per_status[19:16], v[10:7]);
      check($sformatf("R3/R8 vec%0d tok", i), per_status[21:20], v[6:5]);
      check($sformatf("R3/R8 vec%0d ch", i), per_status[25:22], v[4:1]);
      check($sformatf("R3/R8 vec%0d term", i), per_status[26], v[0]);
      check($sformatf("R9 vec%0d np untouched", i), np_status[26:16], 11'h008);
    end

    // R10 / R4: pass-through space field
    @(negedge clk);
    per_space = 16'hA5C3; np_space = 16'h1234;
    #1;
    check("R10 per space", per_status[15:0], 16'hA5C3);
    check("R10 np space", np_status[15:0], 16'h1234);

    // R5: fill non-periodic queue, then overflow
    for (int i = 0; i < 8; i++) np_step(1, 0, 2'(i), 4'(i + 8), i[0]);
    check("R5 np full free", np_status[19:16], 0);
    check("R5 no overflow yet", np_overflow, 0);
    check("R4 head fields", np_status[26:20], {1'b0, 4'd8, 2'd0});
    np_step(1, 0, 2'd3, 4'd2, 1'b1);
    check("R5 overflow set", np_overflow, 1);
    check("R5 free stays 0", np_status[19:16], 0);
    check("R9 per overflow clear", per_overflow, 0);
    for (int i = 0; i < 7; i++) np_step(0, 1, 0, 0, 0);
    check("R5 last kept entry", np_status[26:20], {1'b1, 4'd15, 2'd3});
    check("R5 free after pops", np_status[19:16], 7);
    np_step(0, 1, 0, 0, 0);
    check("R5 dropped entry absent", np_status[26:16], 11'h008);
    check("R5 overflow sticky", np_overflow, 1);
    np_step(0, 1, 0, 0, 0);
    check("R6 np empty pop", np_status[19:16], 8);

    // R7 under wrap: push+pop on wrapped non-empty queue
    np_step(1, 0, 2'd2, 4'd6, 1'b0);
    np_step(1, 1, 2'd1, 4'd7, 1'b1);
    check("R7 free unchanged", np_status[19:16], 7);
    check("R7 head advanced", np_status[26:20], {1'b1, 4'd7, 2'd1});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule